// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a sum-of-products programmable logic array. It takes eight product-term lines from the AND array. Three configuration inputs select the cell's mode: two bits shared by every cell and one bit private to this cell. A fourth bit sets the output polarity.

The cell ORs the product terms that the mode selects and passes the result through the polarity XOR. In registered mode the result is also captured in a flip-flop. The cell presents the pin as a data value plus a separate drive-enable, which models a tri-state pad. It also returns a feedback line to the array: from the register in registered mode, or from the pin in the combinational modes.

A synchronous preload input forces the register to any chosen value for test. An array normally places eight of these cells side by side. The parameter `CELL_INDEX` tells each cell its position. The two centre cells of the row cannot be made into dedicated inputs.

Top module: `pld_macrocell`

## Requirements
- R1: In registered mode (syncMode=1, cellSel=0) the register captures (OR of all eight terms) XOR polXor at the rising clock edge. padOut and fbOut both show the inverse of the register.
- R2: In registered mode padOe is the inverse of the active-low global enable oeN.
- R3: In complex mode (syncMode=0, oeTermMode=1), and in the combinational I/O mode (syncMode=1, cellSel=1), the following hold:
  - padOut is the inverse of (OR of termIn[6:0]) XOR polXor, with no clock edge involved.
  - padOe equals termIn[7].
  - fbOut equals padIn.
- R4: Setting polXor to 1 inverts padOut for the same terms in every mode.
- R5: While rst_n is low the register holds 0. In registered mode with oeN=0, padOut, padOe and fbOut therefore all read 1, whatever the value of polXor.
- R6: In simple output mode (syncMode=0, oeTermMode=0, cellSel=0) the following hold:
  - padOut is the inverse of (OR of all eight terms) XOR polXor.
  - padOe is 1.
  - fbOut equals padIn.
- R7: In simple mode with cellSel=1, a cell that is not a centre cell acts as a dedicated input. padOe is 0 and fbOut equals padIn.
- R8: On a centre cell (CELL_INDEX equal to NUM_CELLS/2-1 or NUM_CELLS/2), cellSel=1 in simple mode is ignored. The cell behaves as a simple output with padOe=1.
- R9: preloadEn=1 at a rising edge loads preloadVal into the register, overriding the data path.
- R10: Combinational mode outputs follow changes on termIn, polXor and padIn in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-up reset; clears the register |
| termIn | input | NUM_TERMS | Product terms from the AND array |
| oeN | input | 1 | Global active-low output enable |
| syncMode | input | 1 | Global bit that selects the registered family of modes |
| oeTermMode | input | 1 | Global bit that selects the product-term output enable when syncMode=0 |
| cellSel | input | 1 | Per-cell mode bit |
| polXor | input | 1 | Per-cell polarity control |
| preloadEn | input | 1 | Forces the register load from preloadVal |
| preloadVal | input | 1 | Value to preload |
| padIn | input | 1 | Value sensed on the pin |
| padOut | output | 1 | Data driven toward the pin |
| padOe | output | 1 | Pin drive enable; 0 means high impedance |
| fbOut | output | 1 | Feedback into the AND array |

## Verification
The bench builds two cells with NUM_TERMS=8 and NUM_CELLS=8. One uses CELL_INDEX=0, an edge cell that may become an input. The other uses CELL_INDEX=3, a centre cell. Driving both with the same stimulus shows that the input request is honoured on one cell and refused on the other. With eight terms, the seventh-term boundary used by the product-term enable modes is directly testable.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

  typedef enum logic [2:0] {
    MODE_REG,
    MODE_REG_IO,
    MODE_COMPLEX,
    MODE_SIMPLE_OUT,
    MODE_SIMPLE_IN
  } cellMode_e;

  typedef enum logic [1:0] {
    OE_GLOBAL,
    OE_TERM,
    OE_ON,
    OE_OFF
  } oeSrc_e;

  typedef struct packed {
    logic   allTerms;
    logic   regPath;
    logic   fbFromPin;
    oeSrc_e oeSrc;
  } cellStrobes_t;

endpackage

// File: rtl/pld_cell_ctrl.sv
module pld_cell_ctrl
  import pld_cell_pkg::*;
#(
  parameter int CELL_INDEX = 0,
  parameter int NUM_CELLS  = 8
) (
  input  logic         syncMode,
  input  logic         oeTermMode,
  input  logic         cellSel,
  output cellMode_e    mode,
  output cellStrobes_t strobes
);

  localparam bit IsCentre = (CELL_INDEX == NUM_CELLS / 2 - 1) ||
                            (CELL_INDEX == NUM_CELLS / 2);

  always_comb begin
    if (syncMode) begin
      mode = cellSel ? MODE_REG_IO : MODE_REG;
    end else if (oeTermMode) begin
      mode = MODE_COMPLEX;
    end else if (cellSel && !IsCentre) begin
      mode = MODE_SIMPLE_IN;
    end else begin
      mode = MODE_SIMPLE_OUT;
    end
  end

  always_comb begin
    strobes = '{allTerms: 1'b1, regPath: 1'b0, fbFromPin: 1'b1, oeSrc: OE_ON};
    unique case (mode)
      MODE_REG: begin
        strobes.regPath   = 1'b1;
        strobes.fbFromPin = 1'b0;
        strobes.oeSrc     = OE_GLOBAL;
      end
      MODE_REG_IO, MODE_COMPLEX: begin
        strobes.allTerms = 1'b0;
        strobes.oeSrc    = OE_TERM;
      end
      MODE_SIMPLE_IN: strobes.oeSrc = OE_OFF;
      default:        strobes.oeSrc = OE_ON;
    endcase
  end

endmodule

// File: rtl/pld_cell_datapath.sv
module pld_cell_datapath
  import pld_cell_pkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TERMS-1:0] termIn,
  input  logic                 polXor,
  input  logic                 oeN,
  input  logic                 preloadEn,
  input  logic                 preloadVal,
  input  logic                 padIn,
  input  cellStrobes_t         strobes,
  output logic                 padOut,
  output logic                 padOe,
  output logic                 fbOut
);

  localparam int OeTerm = NUM_TERMS - 1;

  logic sumAll, sumData, orSel, dVal, qReg;

  assign sumAll  = |termIn;
  assign sumData = |termIn[OeTerm-1:0];
  assign orSel   = strobes.allTerms ? sumAll : sumData;
  assign dVal    = orSel ^ polXor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qReg <= 1'b0;
    end else if (preloadEn) begin
      qReg <= preloadVal;
    end else if (strobes.regPath) begin
      qReg <= dVal;
    end
  end

  assign padOut = strobes.regPath ? ~qReg : ~dVal;
  assign fbOut  = strobes.fbFromPin ? padIn : ~qReg;

  always_comb begin
    unique case (strobes.oeSrc)
      OE_GLOBAL: padOe = ~oeN;
      OE_TERM:   padOe = termIn[OeTerm];
      OE_ON:     padOe = 1'b1;
      default:   padOe = 1'b0;
    endcase
  end

  // R1: the registered path shows the inverse of the sum sampled one edge earlier
  p_reg_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.regPath && !preloadEn) |=>
      (!strobes.regPath || padOut == ~($past(sumAll) ^ $past(polXor))));

  // R9: preload wins over the data path
  p_preload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    preloadEn |=> (strobes.fbFromPin || fbOut == ~$past(preloadVal)));

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_cell_pkg::*;
#(
  parameter int NUM_TERMS  = 8,
  parameter int NUM_CELLS  = 8,
  parameter int CELL_INDEX = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TERMS-1:0] termIn,
  input  logic                 oeN,
  input  logic                 syncMode,
  input  logic                 oeTermMode,
  input  logic                 cellSel,
  input  logic                 polXor,
  input  logic                 preloadEn,
  input  logic                 preloadVal,
  input  logic                 padIn,
  output logic                 padOut,
  output logic                 padOe,
  output logic                 fbOut
);

  localparam bit IsCentre = (CELL_INDEX == NUM_CELLS / 2 - 1) ||
                            (CELL_INDEX == NUM_CELLS / 2);

  cellMode_e    mode;
  cellStrobes_t strobes;

  pld_cell_ctrl #(.CELL_INDEX(CELL_INDEX), .NUM_CELLS(NUM_CELLS)) u_ctrl (
    .syncMode(syncMode), .oeTermMode(oeTermMode), .cellSel(cellSel),
    .mode(mode), .strobes(strobes)
  );

  pld_cell_datapath #(.NUM_TERMS(NUM_TERMS)) u_dp (
    .clk(clk), .rst_n(rst_n), .termIn(termIn), .polXor(polXor), .oeN(oeN),
    .preloadEn(preloadEn), .preloadVal(preloadVal), .padIn(padIn),
    .strobes(strobes), .padOut(padOut), .padOe(padOe), .fbOut(fbOut)
  );

  // R2: the global pin gates the registered output
  p_global_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (syncMode && !cellSel) |-> (padOe == !oeN));

  // R3: the top product term is the enable in the term-enable modes
  p_term_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((syncMode && cellSel) || (!syncMode && oeTermMode)) |->
      (padOe == termIn[NUM_TERMS-1] && fbOut == padIn));

  generate
    if (IsCentre) begin : g_centre
      // R8: a centre cell never floats in simple mode
      p_centre_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!syncMode && !oeTermMode) |-> padOe);
    end else begin : g_edge
      // R7: a dedicated input never drives and feeds its pin back
      p_input_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!syncMode && !oeTermMode && cellSel) |-> (!padOe && fbOut == padIn));
    end
  endgenerate

endmodule

// File: tb/tb_pld_macrocell.sv
module tb_pld_macrocell;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] termIn;
  logic       oeN, syncMode, oeTermMode, cellSel, polXor;
  logic       preloadEn, preloadVal, padIn;
  logic       padOut, padOe, fbOut;
  logic       midOut, midOe, midFb;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  pld_macrocell #(.NUM_TERMS(8), .NUM_CELLS(8), .CELL_INDEX(0)) dut (
    .clk(clk), .rst_n(rst_n), .termIn(termIn), .oeN(oeN), .syncMode(syncMode),
    .oeTermMode(oeTermMode), .cellSel(cellSel), .polXor(polXor),
    .preloadEn(preloadEn), .preloadVal(preloadVal), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .fbOut(fbOut));

  pld_macrocell #(.NUM_TERMS(8), .NUM_CELLS(8), .CELL_INDEX(3)) dutMid (
    .clk(clk), .rst_n(rst_n), .termIn(termIn), .oeN(oeN), .syncMode(syncMode),
    .oeTermMode(oeTermMode), .cellSel(cellSel), .polXor(polXor),
    .preloadEn(preloadEn), .preloadVal(preloadVal), .padIn(padIn),
    .padOut(midOut), .padOe(midOe), .fbOut(midFb));

  // {sync, oeTerm, cellSel, pol, terms[7:0], padIn, expected {out, oe, fb}}
  localparam int NumVec = 9;
  localparam logic [15:0] Vecs [NumVec] = '{
    16'h0006, 16'h080B, 16'h1002, 16'h2FF9, 16'h4806,
    16'h4019, 16'h5846, 16'hAC0B, 16'hB000
  };

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {out,oe,fb}=%b expected %b", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [15:0] v);
    if (v[15] || v[14]) return "R3";
    if (v[13])          return "R7";
    if (v[12])          return "R4";
    return "R6";
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; termIn = 8'h00; oeN = 1'b0; syncMode = 1'b1; oeTermMode = 1'b0;
    cellSel = 1'b0; polXor = 1'b0; preloadEn = 1'b0; preloadVal = 1'b0; padIn = 1'b0;

    // R5: reset state, both polarities
    @(negedge clk);
    check("R5 pol0", {padOut, padOe, fbOut}, 3'b111);
    polXor = 1'b1; termIn = 8'hFF;
    @(negedge clk);
    check("R5 pol1", {padOut, padOe, fbOut}, 3'b111);
    rst_n = 1'b1;

    // R3 R4 R6 R7 R10: table walk, checked in the same cycle without an edge
    for (int i = 0; i < NumVec; i++) begin
      @(negedge clk);
      {syncMode, oeTermMode, cellSel, polXor, termIn, padIn} = Vecs[i][15:3];
      #1;
      check(tagOf(Vecs[i]), {padOut, padOe, fbOut}, Vecs[i][2:0]);
    end

    // R10: the combinational output follows a term change with no clock edge
    @(negedge clk);
    {syncMode, oeTermMode, cellSel, polXor, padIn} = 5'b00000; termIn = 8'h00;
    #1; termIn = 8'h01; #1;
    check("R10", {padOut, padOe, fbOut}, 3'b010);

    // R1: registered capture of all eight terms
    @(negedge clk);
    syncMode = 1'b1; cellSel = 1'b0; oeN = 1'b0; polXor = 1'b0; termIn = 8'h80;
    @(negedge clk);
    check("R1 set", {padOut, padOe, fbOut}, 3'b010);
    termIn = 8'h00;
    @(negedge clk);
    check("R1 clear", {padOut, padOe, fbOut}, 3'b111);
    // R4: polarity on the registered path
    polXor = 1'b1;
    @(negedge clk);
    check("R4 reg", {padOut, padOe, fbOut}, 3'b010);
    // R2: global enable released
    oeN = 1'b1; #1;
    check("R2", {padOut, padOe, fbOut}, 3'b000);
    oeN = 1'b0;

    // R9: preload overrides the data path in both directions
    polXor = 1'b0; termIn = 8'hFF; preloadEn = 1'b1; preloadVal = 1'b0;
    @(negedge clk);
    check("R9 load0", {padOut, padOe, fbOut}, 3'b111);
    termIn = 8'h00; preloadVal = 1'b1;
    @(negedge clk);
    check("R9 load1", {padOut, padOe, fbOut}, 3'b010);
    preloadEn = 1'b0;

    // R8: input request refused on the centre cell, honoured on the edge cell
    @(negedge clk);
    {syncMode, oeTermMode, cellSel, polXor, padIn} = 5'b00100; termIn = 8'h00;
    #1;
    check("R8 centre", {midOut, midOe, midFb}, 3'b110);
    check("R7 edge", {padOe, fbOut}, 2'b00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule